// File: doc/BRIEF.md
# Selectable-Source Pulse Duration Front End

This block is the measurement front end for a bank of pulse channels. Each channel receives two candidate pulse signals: one produced on chip and one that arrives from outside, unrelated to the system clock. A per-channel select bit picks one of them. The chosen signal is brought into the system clock domain by a flop chain. From there it drives two things: a single-cycle strobe that marks each high-to-low transition, and a saturating counter that turns the length of the high phase into a cycle count.

A measurement round begins with the trigger. The trigger clears every channel's counter and arms it. An armed counter adds one for each cycle in which its synchronized signal is high. It stops at the first falling edge and keeps that value until the next trigger. The strobes do not depend on arming, so a downstream selector can rank channels by the order in which their strobes appear. The counts can be read out at any later time.

Top module: `pulse_tdc_front`

## Requirements
- R1: For channel c, select bit `src_sel[c]` = 1 routes `pulse_ext[c]` into the channel, and 0 routes `pulse_int[c]`. The unselected input has no effect on that channel.
- R2: `sync_out[c]` equals the selected input as it stood two rising clock edges earlier. The input is sampled at the first of those edges.
- R3: `fall_strobe[c]` is high for exactly one cycle each time `sync_out[c]` goes from 1 to 0. That cycle is the first one in which `sync_out[c]` reads 0. The strobe fires whether or not the counter is armed.
- R4: A cycle with `trig` high sets every channel's count to 0 and arms the counter.
- R5: An armed counter increments once per cycle while `sync_out[c]` is 1. A pulse that starts after the trigger and is N cycles wide therefore gives a count of N. Channel c's count is on `dur_flat[12*c+11 : 12*c]`.
- R6: The count saturates at 4095 and never wraps.
- R7: The first falling edge after a trigger disarms the counter. Later pulses leave the count unchanged until the next trigger.
- R8: After reset and before the first trigger, counts stay 0 regardless of input pulses.
- R9: If `trig` and a falling edge fall in the same cycle, the trigger wins: the count is 0 and the counter is armed.
- R10: While `rst_n` is low, `sync_out`, `fall_strobe` and all counts are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the internal release is synchronized to `clk` |
| trig | input | 1 | Synchronous start of a measurement round |
| src_sel | input | 8 | Per-channel source select, 1 = external |
| pulse_int | input | 8 | On-chip pulse inputs |
| pulse_ext | input | 8 | External asynchronous pulse inputs |
| sync_out | output | 8 | Selected inputs after synchronization |
| dur_flat | output | 96 | Eight 12-bit durations, channel c at bits 12c+11..12c |
| fall_strobe | output | 8 | One-cycle falling-edge strobes |

## Verification
Two functions can land in the same cycle: the trigger that rearms a counter and the falling edge that disarms it. The bench provokes this by watching for a strobe and raising `trig` so that both are seen at the same clock edge. It judges the result from outside in two steps. First, all counts must read 0. Second, a following pulse with no new trigger must be measured in full, which is only possible if the trigger won. Width sweeps with mixed select patterns and decoy widths on the unselected input cover the main path. A run longer than 4095 cycles covers saturation.

// File: rtl/tdcfe_pkg.sv
`timescale 1ns/1ps
package tdcfe_pkg;
  localparam int unsigned CH_DEF    = 8;
  localparam int unsigned DUR_W_DEF = 12;
  localparam int unsigned SYNC_DEF  = 2;

  function automatic logic pick_src(input logic use_ext, input logic a_int, input logic a_ext);
    return use_ext ? a_ext : a_int;
  endfunction
endpackage

// File: rtl/tdcfe_sync.sv
`timescale 1ns/1ps
module tdcfe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tdcfe_edge.sv
`timescale 1ns/1ps
module tdcfe_edge (
  input  logic clk,
  input  logic rst_ni,
  input  logic level_i,
  output logic fall_o
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = level_i;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= prev_d;
  end

  assign fall_o = prev_q & ~level_i;

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tdcfe_counter.sv
`timescale 1ns/1ps
module tdcfe_counter #(
  parameter int unsigned DUR_W = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             level_i,
  input  logic             fall_i,
  output logic [DUR_W-1:0] dur_o
);
  localparam logic [DUR_W-1:0] DUR_MAX = '1;

  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;
  logic             cnt_en;

  assign cnt_en = trig_i | arm_q;

  always_comb begin
    cnt_d = cnt_q;
    arm_d = arm_q;
    if (trig_i) begin
      cnt_d = '0;
      arm_d = 1'b1;
    end else if (arm_q) begin
      if (fall_i) begin
        arm_d = 1'b0;
      end else if (level_i && (cnt_q != DUR_MAX)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign dur_o = cnt_q;

  assert_trig_clears_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    trig_i |=> (dur_o == '0));
  assert_no_decrease_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !trig_i |=> (dur_o >= $past(dur_o)));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!trig_i && dur_o == DUR_MAX) |=> (dur_o == DUR_MAX));
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!trig_i && !arm_q) |=> $stable(dur_o));
  assert_trig_wins_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (trig_i && fall_i) |=> (arm_q && dur_o == '0));
endmodule

// File: rtl/pulse_tdc_front.sv
`timescale 1ns/1ps
module pulse_tdc_front
  import tdcfe_pkg::*;
#(
  parameter int unsigned NUM_CH = CH_DEF,
  parameter int unsigned DUR_W  = DUR_W_DEF,
  parameter int unsigned SYNC_N = SYNC_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    trig,
  input  logic [NUM_CH-1:0]       src_sel,
  input  logic [NUM_CH-1:0]       pulse_int,
  input  logic [NUM_CH-1:0]       pulse_ext,
  output logic [NUM_CH-1:0]       sync_out,
  output logic [NUM_CH*DUR_W-1:0] dur_flat,
  output logic [NUM_CH-1:0]       fall_strobe
);
  logic [1:0] rst_pipe_q;
  logic [1:0] rst_pipe_d;
  logic       rst_ni;

  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_ni = rst_pipe_q[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             chosen;
    logic             lvl;
    logic             fall;
    logic [DUR_W-1:0] dur;

    assign chosen = pick_src(src_sel[c], pulse_int[c], pulse_ext[c]);

    tdcfe_sync #(.STAGES(SYNC_N)) u_sync (
      .clk(clk), .rst_ni(rst_ni), .async_i(chosen), .sync_o(lvl)
    );

    tdcfe_edge u_edge (
      .clk(clk), .rst_ni(rst_ni), .level_i(lvl), .fall_o(fall)
    );

    tdcfe_counter #(.DUR_W(DUR_W)) u_cnt (
      .clk(clk), .rst_ni(rst_ni), .trig_i(trig), .level_i(lvl),
      .fall_i(fall), .dur_o(dur)
    );

    assign sync_out[c]                = lvl;
    assign fall_strobe[c]             = fall;
    assign dur_flat[c*DUR_W +: DUR_W] = dur;
  end

  assert_reset_zero_R10: assert property (@(posedge clk)
    !rst_ni |-> (sync_out == '0 && fall_strobe == '0 && dur_flat == '0));
endmodule

// File: tb/sim_pulse_tdc_front.sv
`timescale 1ns/1ps
module sim_pulse_tdc_front;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              trig;
  logic [NCH-1:0]    src_sel;
  logic [NCH-1:0]    pulse_int;
  logic [NCH-1:0]    pulse_ext;
  logic [NCH-1:0]    sync_out;
  logic [NCH*DW-1:0] dur_flat;
  logic [NCH-1:0]    fall_strobe;

  int n_chk  = 0;
  int n_fail = 0;
  int sc [NCH];

  always #2.5 clk = ~clk;

  pulse_tdc_front u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .src_sel(src_sel),
    .pulse_int(pulse_int), .pulse_ext(pulse_ext), .sync_out(sync_out),
    .dur_flat(dur_flat), .fall_strobe(fall_strobe)
  );

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) if (fall_strobe[c] === 1'b1) sc[c]++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dur_of(input int c);
    return int'(dur_flat[c*DW +: DW]);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic clear_sc();
    @(posedge clk);
    for (int c = 0; c < NCH; c++) sc[c] = 0;
  endtask

  // drive int/ext widths per channel starting together, then settle
  task automatic burst(input int wi [NCH], input int we [NCH]);
    int mx = 0;
    for (int c = 0; c < NCH; c++) begin
      if (wi[c] > mx) mx = wi[c];
      if (we[c] > mx) mx = we[c];
    end
    for (int t = 0; t < mx; t++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        pulse_int[c] = (t < wi[c]);
        pulse_ext[c] = (t < we[c]);
      end
    end
    @(negedge clk);
    pulse_int = '0;
    pulse_ext = '0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_all(input int exp_d [NCH], input int exp_s [NCH], input string rd, input string rs);
    for (int c = 0; c < NCH; c++) begin
      chk(dur_of(c) == exp_d[c], rd, dur_of(c), exp_d[c]);
      chk(sc[c] == exp_s[c], rs, sc[c], exp_s[c]);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int wi [NCH];
    int we [NCH];
    int ed [NCH];
    int es [NCH];
    int wsel;
    for (int c = 0; c < NCH; c++) sc[c] = 0;
    rst_n = 1'b0; trig = 1'b0; src_sel = '0; pulse_int = '1; pulse_ext = '1;

    // R10: reset state with inputs active
    repeat (4) @(negedge clk);
    chk(sync_out == '0, "R10 sync", int'(sync_out), 0);
    chk(fall_strobe == '0, "R10 strobe", int'(fall_strobe), 0);
    chk(dur_flat == '0, "R10 dur", int'(dur_flat[31:0]), 0);
    pulse_int = '0; pulse_ext = '0;
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: two-edge latency, sel 0x0F takes ext on ch0..3
    src_sel = 8'h0F;
    pulse_int = 8'hF0; pulse_ext = 8'h0F;
    @(negedge clk);
    chk(sync_out == 8'h00, "R2 one edge", int'(sync_out), 0);
    @(negedge clk);
    chk(sync_out == 8'hFF, "R2 two edges", int'(sync_out), 255);
    pulse_int = 8'hFF; pulse_ext = 8'h00;
    @(negedge clk); @(negedge clk);
    chk(sync_out == 8'hF0, "R1 R2 switch", int'(sync_out), 240);
    pulse_int = '0;
    repeat (6) @(negedge clk);

    // R8: no trigger yet, counts stay 0, strobes still fire (R3)
    src_sel = 8'h00;
    clear_sc();
    for (int c = 0; c < NCH; c++) begin wi[c] = 10; we[c] = 0; ed[c] = 0; es[c] = 1; end
    burst(wi, we);
    check_all(ed, es, "R8 untriggered", "R3 strobe");

    // R1 R5: internal sources, decoy external widths
    src_sel = 8'h00;
    pulse_trig(); clear_sc();
    for (int c = 0; c < NCH; c++) begin wi[c] = c*3+1; we[c] = 50; ed[c] = c*3+1; es[c] = 1; end
    burst(wi, we);
    check_all(ed, es, "R1 R5 int", "R3 strobe");

    // R7: later pulses ignored without trigger
    clear_sc();
    for (int c = 0; c < NCH; c++) begin wi[c] = 40 - c; we[c] = 0; end
    burst(wi, we);
    check_all(ed, es, "R7 frozen", "R3 strobe");

    // R1 R5: external sources
    src_sel = 8'hFF;
    pulse_trig(); clear_sc();
    for (int c = 0; c < NCH; c++) begin we[c] = c*5+2; wi[c] = 90; ed[c] = c*5+2; es[c] = 1; end
    burst(wi, we);
    check_all(ed, es, "R1 R5 ext", "R3 strobe");

    // R1 R5 R4: sweep of widths and select patterns
    for (int w = 1; w <= 48; w++) begin
      src_sel = 8'(w * 37);
      pulse_trig(); clear_sc();
      for (int c = 0; c < NCH; c++) begin
        wsel = ((w + c*7) % 48) + 1;
        if (src_sel[c]) begin we[c] = wsel; wi[c] = wsel + 5; end
        else            begin wi[c] = wsel; we[c] = wsel + 5; end
        ed[c] = wsel; es[c] = 1;
      end
      burst(wi, we);
      check_all(ed, es, "R1 R4 R5 sweep", "R3 sweep");
    end

    // R6: saturation; width 0 gives no strobe
    src_sel = 8'h00;
    pulse_trig(); clear_sc();
    for (int c = 0; c < NCH; c++) begin wi[c] = 0; we[c] = 0; ed[c] = 0; es[c] = 0; end
    wi[0] = 4100; ed[0] = 4095; es[0] = 1;
    wi[1] = 4095; ed[1] = 4095; es[1] = 1;
    wi[2] = 4094; ed[2] = 4094; es[2] = 1;
    wi[3] = 1;    ed[3] = 1;    es[3] = 1;
    burst(wi, we);
    check_all(ed, es, "R6 saturate", "R3 strobe");

    // R9: trigger in the same cycle as the strobe
    src_sel = 8'h00;
    pulse_trig();
    @(negedge clk) pulse_int = '1;
    repeat (20) @(negedge clk);
    pulse_int = '0;
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      if (fall_strobe[0] === 1'b1) break;
    end
    chk(fall_strobe == 8'hFF, "R9 strobe seen", int'(fall_strobe), 255);
    trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    for (int c = 0; c < NCH; c++) chk(dur_of(c) == 0, "R9 cleared", dur_of(c), 0);
    clear_sc();
    for (int c = 0; c < NCH; c++) begin wi[c] = 13; we[c] = 0; ed[c] = 13; es[c] = 1; end
    burst(wi, we);
    check_all(ed, es, "R9 rearmed", "R3 strobe");

    // R4: trigger alone clears a held count
    pulse_trig();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) chk(dur_of(c) == 0, "R4 clear", dur_of(c), 0);

    summary();
  end
endmodule